// File: doc/BRIEF.md
# USB NRZI Packet Transmitter

This block turns a stream of packet bytes into the line levels of a USB differential pair. A start request, taken on a bit-time strobe while the block is idle, begins a packet. The block first sends the sync pattern and then pulls payload bytes one at a time through a ready/valid handshake. The payload holds the PID, the fields and the CRC, all produced upstream. Each byte leaves least significant bit first. A zero is inserted after every run of six ones, and every bit is NRZI-coded onto the pair.

When the byte flagged as last has been fully sent, including any stuffed zero it caused, the block drives the end-of-packet trailer. The same trailer is sent if the upstream source has no byte ready when one is due. The trailer is two bit times of single-ended zero followed by one bit time of idle J. The output enable then drops and a one-cycle done pulse is raised.

All line changes happen on clock edges that follow a cycle with the bit strobe high, so the strobe alone sets the bit rate. A parameter chooses full-speed polarity, where J has D+ high, or low-speed polarity, where J has D- high.

Top module: `usb_nrzi_tx`

## Requirements
- R1: While reset is held, oe, busy, done and tx_ready are 0 and the pair shows J (full speed: dp=1, dm=0).
- R2: dp, dm and oe change only on a clock edge whose preceding cycle had bit_tick high.
- R3: start seen with bit_tick high while not busy makes the next cycle show oe=1, busy=1 and the pair at K (full speed: dp=0, dm=1), which is the first sync zero.
- R4: Each coded bit is sent in one bit time. A 0 inverts the pair relative to the previous bit time and a 1 leaves it unchanged. Coding begins from J.
- R5: The first eight coded bits of every packet are 0,0,0,0,0,0,0,1.
- R6: tx_ready is high only in a bit_tick cycle in which a new byte's first bit is due. A byte is taken when tx_ready and tx_valid are both high, and its bits go out bit 0 first.
- R7: After six consecutive coded ones, one zero is inserted. Any zero, stuffed or not, restarts the run count. This applies across sync, payload and the final bit before the trailer.
- R8: A stuffed zero delays the next payload bit, and any byte fetch, by exactly one bit time.
- R9: After the last byte (tx_last=1) and any stuffed zero, the pair shows SE0 (dp=0, dm=0) for two bit times, then J for one bit time, and then oe falls.
- R10: If tx_valid is low while tx_ready is high, no byte is taken and the same trailer as R9 begins on that bit time.
- R11: busy is high from the start bit time until oe falls. done is a single-cycle pulse on the edge where oe falls.
- R12: While busy, start has no effect. While idle, start in a cycle without bit_tick has no effect, and the pair stays J with oe low.
- R13: dp and dm are never both high. Whenever oe is low the pair shows J.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| start | input | 1 | Request to begin a packet |
| tx_data | input | DATA_W | Payload byte |
| tx_valid | input | 1 | tx_data holds a byte |
| tx_last | input | 1 | Current byte is the final one |
| tx_ready | output | 1 | Byte is consumed this cycle if valid |
| dp | output | 1 | D+ drive level |
| dm | output | 1 | D- drive level |
| oe | output | 1 | Driver enable |
| busy | output | 1 | Packet in progress |
| done | output | 1 | Packet finished pulse |

## Verification
Several payload patterns are used, and each one isolates a different part of the behaviour.

Mixed bytes such as 0xC3 and 0x5A check NRZI coding and bit order without any stuffing. Runs of 0xFF show stuffing that crosses byte boundaries and holds back the ready handshake. A final byte of 0xFC forces a stuffed zero between the last payload bit and the trailer.

A source that runs dry without flagging a last byte separates the underrun ending from the normal ending. A packet sent with an irregular strobe, with start held high across it, shows that outputs follow the strobe only and that start is ignored while busy.

The pair is also decoded and destuffed independently, and the recovered bits are compared with the sync pattern and the bytes that were sent.

// File: rtl/utx_pkg.sv
package utx_pkg;
   typedef enum logic [1:0] {
      UTX_IDLE = 2'd0,
      UTX_PKT  = 2'd1,
      UTX_SE0  = 2'd2,
      UTX_JEND = 2'd3
   } utx_state_e;
endpackage

// File: rtl/utx_run_ctr.sv
// Counts consecutive ones emitted on the line; flags when a stuffed zero is due.
module utx_run_ctr #(
   parameter int RUN_LEN = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic step,
   input  logic bit_val,
   output logic stuff_due
);
   localparam int CW = $clog2(RUN_LEN + 1);

   logic [CW-1:0] cnt;
   logic [CW-1:0] base;

   assign base      = clr ? '0 : cnt;
   assign stuff_due = (cnt == CW'(RUN_LEN));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (step)
         cnt <= bit_val ? base + 1'b1 : '0;
      else if (clr)
         cnt <= '0;
   end
endmodule

// File: rtl/utx_shifter.sv
// Holds the remaining bits of the current byte, least significant first.
module utx_shifter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_en,
   input  logic [W-1:0] load_val,
   input  logic         shift_en,
   output logic         head,
   output logic         empty
);
   localparam int CW = $clog2(W + 1);

   logic [W-1:0]  sh;
   logic [CW-1:0] left;

   assign head  = sh[0];
   assign empty = (left == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '0;
         left <= '0;
      end else if (load_en) begin
         sh   <= load_val >> 1;
         left <= CW'(W - 1);
      end else if (shift_en) begin
         sh   <= sh >> 1;
         left <= left - 1'b1;
      end
   end
endmodule

// File: rtl/utx_line.sv
// Line state registers: NRZI level, SE0 flag and driver enable; polarity by generate.
module utx_line #(
   parameter bit LOW_SPEED = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic bit_en,
   input  logic bit_val,
   input  logic se0_set,
   input  logic j_set,
   input  logic oe_next,
   output logic dp,
   output logic dm,
   output logic oe
);
   logic lvl_j;
   logic se0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_j <= 1'b1;
         se0   <= 1'b0;
         oe    <= 1'b0;
      end else if (tick) begin
         oe <= oe_next;
         if (bit_en) begin
            se0 <= 1'b0;
            if (!bit_val)
               lvl_j <= ~lvl_j;
         end else if (se0_set) begin
            se0 <= 1'b1;
         end else if (j_set) begin
            se0   <= 1'b0;
            lvl_j <= 1'b1;
         end
      end
   end

   generate
      if (LOW_SPEED) begin : g_ls
         assign dp = ~se0 & ~lvl_j;
         assign dm = ~se0 &  lvl_j;
      end else begin : g_fs
         assign dp = ~se0 &  lvl_j;
         assign dm = ~se0 & ~lvl_j;
      end
   endgenerate
endmodule

// File: rtl/usb_nrzi_tx.sv
module usb_nrzi_tx
   import utx_pkg::*;
#(
   parameter int          DATA_W    = 8,
   parameter int          RUN_LEN   = 6,
   parameter int          SE0_BITS  = 2,
   parameter logic [7:0]  SYNC_BYTE = 8'h80,
   parameter bit          LOW_SPEED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  logic              start,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_valid,
   input  logic              tx_last,
   output logic              tx_ready,
   output logic              dp,
   output logic              dm,
   output logic              oe,
   output logic              busy,
   output logic              done
);
   localparam int SCW = $clog2(SE0_BITS + 1);

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("usb_nrzi_tx: DATA_W must be 8 to match the sync byte");
      end
      if (RUN_LEN < 1) begin : g_bad_run
         $error("usb_nrzi_tx: RUN_LEN must be at least 1");
      end
      if (SE0_BITS < 1) begin : g_bad_se0
         $error("usb_nrzi_tx: SE0_BITS must be at least 1");
      end
   endgenerate

   utx_state_e      st;
   logic [SCW-1:0]  se0_cnt;
   logic            last_q;
   logic            done_q;

   logic            stuff;
   logic            sh_head;
   logic            sh_empty;
   logic            in_pkt;
   logic            take_start;
   logic            need_byte;
   logic            load_data;
   logic            end_pkt;
   logic            shift_en;
   logic            emit;
   logic            ebit;
   logic            load_en;
   logic [DATA_W-1:0] load_val;
   logic            se0_done;
   logic            oe_next;

   assign in_pkt     = (st == UTX_PKT);
   assign take_start = bit_tick && (st == UTX_IDLE) && start;
   assign need_byte  = in_pkt && !stuff && sh_empty;
   assign tx_ready   = bit_tick && need_byte && !last_q;
   assign load_data  = tx_ready && tx_valid;
   assign end_pkt    = bit_tick && need_byte && (last_q || !tx_valid);
   assign shift_en   = bit_tick && in_pkt && !stuff && !sh_empty;
   assign emit       = take_start || load_data || shift_en || (bit_tick && in_pkt && stuff);
   assign ebit       = take_start ? SYNC_BYTE[0] :
                       load_data  ? tx_data[0]   :
                       shift_en   ? sh_head      : 1'b0;
   assign load_en    = take_start || load_data;
   assign load_val   = take_start ? DATA_W'(SYNC_BYTE) : tx_data;
   assign se0_done   = (st == UTX_SE0) && (se0_cnt == SCW'(SE0_BITS));
   assign oe_next    = (st == UTX_IDLE) ? take_start : (st != UTX_JEND);
   assign busy       = (st != UTX_IDLE);
   assign done       = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= UTX_IDLE;
         se0_cnt <= '0;
         last_q  <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         done_q <= bit_tick && (st == UTX_JEND);
         if (bit_tick) begin
            unique case (st)
               UTX_IDLE: if (start) begin
                  st     <= UTX_PKT;
                  last_q <= 1'b0;
               end
               UTX_PKT: begin
                  if (load_data)
                     last_q <= tx_last;
                  if (end_pkt) begin
                     st      <= UTX_SE0;
                     se0_cnt <= SCW'(1);
                  end
               end
               UTX_SE0: begin
                  if (se0_done)
                     st <= UTX_JEND;
                  else
                     se0_cnt <= se0_cnt + 1'b1;
               end
               UTX_JEND: st <= UTX_IDLE;
               default:  st <= UTX_IDLE;
            endcase
         end
      end
   end

   utx_run_ctr #(.RUN_LEN(RUN_LEN)) u_run (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (take_start),
      .step      (emit),
      .bit_val   (ebit),
      .stuff_due (stuff)
   );

   utx_shifter #(.W(DATA_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (load_en),
      .load_val (load_val),
      .shift_en (shift_en),
      .head     (sh_head),
      .empty    (sh_empty)
   );

   utx_line #(.LOW_SPEED(LOW_SPEED)) u_line (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (bit_tick),
      .bit_en  (emit),
      .bit_val (ebit),
      .se0_set (end_pkt),
      .j_set   (bit_tick && se0_done),
      .oe_next (oe_next),
      .dp      (dp),
      .dm      (dm),
      .oe      (oe)
   );
endmodule

// File: rtl/utx_chk.sv
module utx_chk #(
   parameter bit LOW_SPEED = 1'b0
) (
   input logic clk,
   input logic rst_n,
   input logic bit_tick,
   input logic start,
   input logic tx_ready,
   input logic dp,
   input logic dm,
   input logic oe,
   input logic busy,
   input logic done
);
   localparam logic J_DP = LOW_SPEED ? 1'b0 : 1'b1;

   // R13
   no_se1_chk: assert property (@(posedge clk) disable iff (!rst_n) !(dp && dm));

   // R13
   idle_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !oe |-> (dp == J_DP && dm == !J_DP));

   // R2
   tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_tick |=> $stable({dp, dm, oe}));

   // R3
   sop_k_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_tick && start && !busy) |=> (oe && busy && dp == !J_DP && dm == J_DP));

   // R6
   ready_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready |-> (bit_tick && busy));

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R11
   done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> (!busy && !oe && $past(oe)));
endmodule

bind usb_nrzi_tx utx_chk #(.LOW_SPEED(LOW_SPEED)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bit_tick (bit_tick),
   .start    (start),
   .tx_ready (tx_ready),
   .dp       (dp),
   .dm       (dm),
   .oe       (oe),
   .busy     (busy),
   .done     (done)
);

// File: tb/sim_usb_nrzi_tx.sv
module sim_usb_nrzi_tx;
   localparam int CLK_PERIOD = 10;
   localparam int RUN        = 6;
   localparam int SE0N       = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_tick = 1'b0;
   logic       start = 1'b0;
   logic [7:0] tx_data = 8'h00;
   logic       tx_valid = 1'b0;
   logic       tx_last = 1'b0;
   logic       tx_ready, dp, dm, oe, busy, done;

   always #(CLK_PERIOD / 2) clk = ~clk;

   usb_nrzi_tx u0 (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .start(start),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last),
      .tx_ready(tx_ready), .dp(dp), .dm(dm), .oe(oe), .busy(busy), .done(done)
   );

   int n_cmp = 0;
   int n_bad = 0;

   // reference model state
   int   m_st = 0;
   int   bq[$];
   int   m_ones = 0;
   bit   m_lvl = 1'b1;
   bit   m_se0 = 1'b0;
   bit   m_oe = 1'b0;
   bit   m_done = 1'b0;
   bit   m_last = 1'b0;
   int   m_se0c = 0;

   // stimulus state
   logic [7:0] src_q[$];
   bit         mark_last = 1'b1;
   bit         tick_rand = 1'b0;
   int         tick_div = 4;
   int         tick_cnt = 0;
   logic [7:0] lfsr = 8'hA5;

   // line decoder state
   int dec_q[$];
   bit prev_dp = 1'b1;
   bit prev_se0 = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic m_emit(input int b);
      if (b == 0) m_lvl = !m_lvl;
      m_ones = (b != 0) ? m_ones + 1 : 0;
      m_se0  = 1'b0;
   endtask

   function automatic bit gen_tick();
      bit t;
      if (tick_rand) begin
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         t = lfsr[0] ^ lfsr[2];
      end else begin
         t = (tick_cnt % tick_div) == 0;
         tick_cnt++;
      end
      return t;
   endfunction

   task automatic cycle();
      bit    tk, pop, mrdy;
      bit    e_dp, e_dm;
      string rtag, ltag;
      tk       = gen_tick();
      bit_tick = tk;
      tx_valid = (src_q.size() > 0);
      tx_data  = (src_q.size() > 0) ? src_q[0] : 8'h00;
      tx_last  = mark_last && (src_q.size() == 1);
      @(negedge clk);
      mrdy = tk && m_st == 1 && m_ones != RUN && bq.size() == 0 && !m_last;
      rtag = (m_st == 1 && m_ones == RUN && bq.size() == 0) ? "R8" : "R6";
      chk(tx_ready === mrdy, rtag, "tx_ready", int'(tx_ready), int'(mrdy));
      pop    = tx_ready && tx_valid;
      m_done = 1'b0;
      ltag   = tk ? "R4" : "R2";
      if (tk) begin
         case (m_st)
            0: begin
               if (start) begin
                  bq = {0, 0, 0, 0, 0, 0, 0, 1};
                  m_ones = 0; m_last = 1'b0; m_oe = 1'b1; m_st = 1;
                  m_emit(bq.pop_front());
                  ltag = "R3";
               end else ltag = "R12";
            end
            1: begin
               if (m_ones == RUN) begin
                  m_emit(0); ltag = "R7";
               end else if (bq.size() > 0) begin
                  m_emit(bq.pop_front());
               end else if (!m_last && tx_valid) begin
                  for (int i = 0; i < 8; i++) bq.push_back(int'(tx_data[i]));
                  m_last = tx_last;
                  m_emit(bq.pop_front());
               end else begin
                  m_se0 = 1'b1; m_se0c = 1; m_st = 2;
                  ltag = m_last ? "R9" : "R10";
               end
            end
            2: begin
               if (m_se0c == SE0N) begin
                  m_se0 = 1'b0; m_lvl = 1'b1; m_st = 3;
               end else m_se0c++;
               ltag = "R9";
            end
            default: begin
               m_oe = 1'b0; m_st = 0; m_done = 1'b1; ltag = "R9";
            end
         endcase
      end
      @(posedge clk);
      #1;
      if (pop) void'(src_q.pop_front());
      e_dp = m_se0 ? 1'b0 : m_lvl;
      e_dm = m_se0 ? 1'b0 : !m_lvl;
      chk(dp === e_dp, ltag, "dp", int'(dp), int'(e_dp));
      chk(dm === e_dm, ltag, "dm", int'(dm), int'(e_dm));
      chk(oe === m_oe, ltag, "oe", int'(oe), int'(m_oe));
      chk(busy === (m_st != 0), "R11", "busy", int'(busy), int'(m_st != 0));
      chk(done === m_done, "R11", "done", int'(done), int'(m_done));
      if (tk) begin
         if (oe && (dp || dm) && !prev_se0)
            dec_q.push_back((dp == prev_dp) ? 1 : 0);
         prev_dp  = dp;
         prev_se0 = oe && !dp && !dm;
      end
   endtask

   task automatic run_packet(input logic [7:0] bytes[$], input bit with_last,
                             input bit hold_start);
      int exp_bits[$];
      int plain[$];
      int ones;
      src_q     = bytes;
      mark_last = with_last;
      dec_q.delete();
      prev_dp  = 1'b1;
      prev_se0 = 1'b0;
      start    = 1'b1;
      do cycle(); while (m_st == 0);
      if (hold_start) begin
         for (int k = 0; k < 30; k++) cycle();
      end
      start = 1'b0;
      while (m_st != 0) cycle();
      for (int k = 0; k < 6; k++) cycle();
      // expected raw bits: sync then payload LSB first
      exp_bits = {0, 0, 0, 0, 0, 0, 0, 1};
      foreach (bytes[b])
         for (int i = 0; i < 8; i++) exp_bits.push_back(int'(bytes[b][i]));
      // destuff the decoded line (R7)
      ones = 0;
      for (int i = 0; i < dec_q.size(); i++) begin
         if (ones == RUN) begin
            chk(dec_q[i] == 0, "R7", "stuffed bit", dec_q[i], 0);
            ones = 0;
         end else begin
            plain.push_back(dec_q[i]);
            ones = (dec_q[i] != 0) ? ones + 1 : 0;
         end
      end
      chk(plain.size() == exp_bits.size(), "R7", "destuffed length",
          plain.size(), exp_bits.size());
      for (int i = 0; i < plain.size() && i < exp_bits.size(); i++)
         chk(plain[i] == exp_bits[i], (i < 8) ? "R5" : "R6", "decoded bit",
             plain[i], exp_bits[i]);
      chk(src_q.size() == 0, "R12", "bytes left", src_q.size(), 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL R11 watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      logic [7:0] pk[$];
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      chk(oe === 1'b0,       "R1", "oe",       int'(oe),       0);
      chk(busy === 1'b0,     "R1", "busy",     int'(busy),     0);
      chk(done === 1'b0,     "R1", "done",     int'(done),     0);
      chk(dp === 1'b1,       "R1", "dp",       int'(dp),       1);
      chk(dm === 1'b0,       "R1", "dm",       int'(dm),       0);
      chk(tx_ready === 1'b0, "R1", "tx_ready", int'(tx_ready), 0);
      rst_n = 1'b1;
      for (int k = 0; k < 10; k++) cycle();

      // plain mixed payload (R4, R6, R9)
      pk = {8'hC3, 8'h5A, 8'h00};
      run_packet(pk, 1'b1, 1'b0);
      // stuffing across bytes and before the trailer (R7, R8)
      pk = {8'hFF, 8'hFF, 8'h7E, 8'hFC};
      run_packet(pk, 1'b1, 1'b0);
      // underrun ending (R10)
      pk = {8'h12, 8'h34};
      run_packet(pk, 1'b0, 1'b0);
      // irregular strobe with start held (R2, R12)
      tick_rand = 1'b1;
      pk = {8'hA5, 8'hFF, 8'h3F, 8'h81};
      run_packet(pk, 1'b1, 1'b1);
      tick_rand = 1'b0;
      // single byte
      tick_div = 3;
      pk = {8'h80};
      run_packet(pk, 1'b1, 1'b0);
      for (int k = 0; k < 8; k++) cycle();

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule